// File: doc/BRIEF.md
# Table-Walking Read DMA with Stream Output

This block is a small DMA master. It reads a short list of words from a memory-mapped read port and sends each word out as one beat on an AXI4-Stream master port. The words it reads come from one fixed column of a table in memory. Each step of a run picks a table row from a parameter list, so one pass can gather the cells of that column in any order. A second parameter list gives the stream destination tag for each step. Every beat also carries a fixed remote message address in TUSER.

A run starts when `enable` is seen high while the block is idle. For each step, the block sends a one-cycle read strobe with the address. It then waits a fixed read latency and captures the returned word. It holds that word on the stream port until the sink accepts it, and only then issues the next read. The final beat of a run carries TLAST. The read port has no handshake: data is valid exactly in the cycle that lies the latency after the strobe.

Top module: `table_stream_dma`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `rd_req` and `m_tvalid` are both 0.
- R2: The read for step k uses address BASE_ADDR + row_k * ROW_STRIDE + COL_OFFSET. Here row_k is bits [k*IDX_W +: IDX_W] of ROW_SEQ, and steps run k = 0, 1, … in order.
- R3: One run issues exactly STEPS reads. After the final beat no further read appears until `enable` is seen again.
- R4: `rd_req` is high for one cycle per read. It is never high while a read is waiting for its data or while `m_tvalid` is high, so at most one read is outstanding.
- R5: If `rd_req` is high in cycle c, the block captures `rd_data` as presented in cycle c+RD_LAT. The captured word appears on `m_tdata` with `m_tvalid` high from cycle c+RD_LAT+1.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tdest` and `m_tlast` keep their values.
- R7: The beat of step k carries `m_tdest` equal to bits [k*DEST_W +: DEST_W] of DEST_SEQ. `m_tuser` always equals REMOTE_TAG.
- R8: `m_tlast` is 1 on the beat of step STEPS-1 only. After that beat is accepted, the block goes idle, with `rd_req` and `m_tvalid` low in the next cycle.
- R9: When a beat that is not the last is accepted (`m_tvalid` and `m_tready` high at an edge), the next read strobe is high in the very next cycle.
- R10: When `enable` is high at an edge while the block is idle, the first read strobe is high in the next cycle. `enable` has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Starts one run when high in idle |
| rd_req | output | 1 | One-cycle read strobe |
| rd_addr | output | ADDR_W | Read address, valid with `rd_req` |
| rd_data | input | DATA_W | Read data, valid RD_LAT cycles after the strobe |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Stream data |
| m_tdest | output | DEST_W | Stream destination tag for the step |
| m_tuser | output | USER_W | Remote message address (REMOTE_TAG) |
| m_tlast | output | 1 | Final beat of the run |

## Verification
The bench has a memory model inside it that returns a word only in the exact latency cycle and drives a marker value in every other cycle. If the latency timer is off by one, the marker shows up on `m_tdata` in the first beat. If the step counter or the pending tag is corrupted, the wrong address appears in the same cycle as the next strobe, or the wrong `m_tdest`/`m_tlast` appears on the next beat. A state machine stuck in the wait or hold state shows within one latency period: `m_tvalid` never rises, or a second strobe appears early.

// File: rtl/dma_tbl_pkg.sv
package dma_tbl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } dma_state_e;

endpackage

// File: rtl/dma_step_table.sv
module dma_step_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int DEST_W = 8,
    parameter int STEPS  = 3,
    parameter int STEP_W = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h43C0_0000,
    parameter logic [ADDR_W-1:0] ROW_STRIDE = '0,
    parameter logic [ADDR_W-1:0] COL_OFFSET = '0,
    parameter logic [STEPS*IDX_W-1:0]  ROW_SEQ  = '0,
    parameter logic [STEPS*DEST_W-1:0] DEST_SEQ = '0
) (
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [DEST_W-1:0] dest,
    output logic              last
);

    logic [ADDR_W-1:0] addr_tab [STEPS];
    logic [DEST_W-1:0] dest_tab [STEPS];

    // One address and one tag per step, fixed at elaboration
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam logic [ADDR_W-1:0] ROW_K = ADDR_W'(ROW_SEQ[k*IDX_W +: IDX_W]);
        assign addr_tab[k] = BASE_ADDR + ROW_K * ROW_STRIDE + COL_OFFSET;
        assign dest_tab[k] = DEST_SEQ[k*DEST_W +: DEST_W];
    end

    always_comb begin
        addr = addr_tab[0];
        dest = dest_tab[0];
        for (int k = 0; k < STEPS; k++) begin
            if (int'(step) == k) begin
                addr = addr_tab[k];
                dest = dest_tab[k];
            end
        end
        last = (int'(step) == STEPS - 1);
    end

endmodule

// File: rtl/dma_latency_timer.sv
module dma_latency_timer #(
    parameter int RD_LAT = 5,
    parameter int CNT_W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(RD_LAT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: the wait after a fresh load is never zero cycles long
    assert_load_not_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

    // R5: once run down, the count stays at zero until the next load
    assert_expired_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/table_stream_dma.sv
module table_stream_dma
    import dma_tbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int DEST_W = 8,
    parameter int USER_W = 8,
    parameter int STEPS  = 3,
    parameter int RD_LAT = 5,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h43C0_0000,
    parameter logic [ADDR_W-1:0] ROW_STRIDE = '0,
    parameter logic [ADDR_W-1:0] COL_OFFSET = '0,
    parameter logic [USER_W-1:0] REMOTE_TAG = 8'h18,
    parameter logic [STEPS*IDX_W-1:0]  ROW_SEQ  = {8'd1, 8'd2, 8'd3},
    parameter logic [STEPS*DEST_W-1:0] DEST_SEQ = {8'd1, 8'd2, 8'd3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [DEST_W-1:0] m_tdest,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast
);

    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int CNT_W  = $clog2(RD_LAT + 1);

    typedef struct packed {
        dma_state_e        state;
        logic [STEP_W-1:0] step;
        logic              rd_req;
        logic [ADDR_W-1:0] rd_addr;
        logic [DEST_W-1:0] pend_dest;
        logic              pend_last;
        logic              tvalid;
        logic [DATA_W-1:0] tdata;
        logic [DEST_W-1:0] tdest;
        logic              tlast;
    } dma_regs_t;

    dma_regs_t r_d, r_q;

    logic [STEP_W-1:0] tbl_step;
    logic [ADDR_W-1:0] tbl_addr;
    logic [DEST_W-1:0] tbl_dest;
    logic              tbl_last;
    logic              tmr_load;
    logic              tmr_expired;

    // Step to look up: first step from idle, otherwise the one after the current
    assign tbl_step = (r_q.state == ST_IDLE) ? '0 : r_q.step + 1'b1;

    dma_step_table #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEST_W(DEST_W),
        .STEPS(STEPS), .STEP_W(STEP_W),
        .BASE_ADDR(BASE_ADDR), .ROW_STRIDE(ROW_STRIDE), .COL_OFFSET(COL_OFFSET),
        .ROW_SEQ(ROW_SEQ), .DEST_SEQ(DEST_SEQ)
    ) u_table (
        .step (tbl_step),
        .addr (tbl_addr),
        .dest (tbl_dest),
        .last (tbl_last)
    );

    dma_latency_timer #(
        .RD_LAT(RD_LAT), .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rd_req = 1'b0;
        tmr_load   = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (enable) begin
                    r_d.step      = '0;
                    r_d.rd_req    = 1'b1;
                    r_d.rd_addr   = tbl_addr;
                    r_d.pend_dest = tbl_dest;
                    r_d.pend_last = tbl_last;
                    r_d.state     = ST_WAIT;
                    tmr_load      = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    r_d.tvalid = 1'b1;
                    r_d.tdata  = rd_data;
                    r_d.tdest  = r_q.pend_dest;
                    r_d.tlast  = r_q.pend_last;
                    r_d.state  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (m_tready) begin
                    r_d.tvalid = 1'b0;
                    if (r_q.tlast) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.step      = tbl_step;
                        r_d.rd_req    = 1'b1;
                        r_d.rd_addr   = tbl_addr;
                        r_d.pend_dest = tbl_dest;
                        r_d.pend_last = tbl_last;
                        r_d.state     = ST_WAIT;
                        tmr_load      = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req   = r_q.rd_req;
    assign rd_addr  = r_q.rd_addr;
    assign m_tvalid = r_q.tvalid;
    assign m_tdata  = r_q.tdata;
    assign m_tdest  = r_q.tdest;
    assign m_tlast  = r_q.tlast;
    assign m_tuser  = REMOTE_TAG;

    // R4: a read strobe lasts exactly one cycle
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4: no new read while a beat is still offered
    assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !rd_req);

    // R5: data cannot appear in the cycle right after the strobe
    assert_no_early_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !m_tvalid);

    // R6: a stalled beat keeps its contents
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tdest) && $stable(m_tlast)));

    // R9: accepting a non-final beat issues the next read at once
    assert_next_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !m_tlast) |=> rd_req);

    // R8: accepting the final beat returns the block to idle
    assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> (!rd_req && !m_tvalid));

endmodule

// File: tb/sim_table_stream_dma.sv
`timescale 1ns/1ps
module sim_table_stream_dma;

    localparam int LAT = 5;
    localparam int NST = 3;
    localparam logic [31:0] BASE   = 32'h4000_0000;
    localparam logic [31:0] STRIDE = 32'h0000_0100;
    localparam logic [31:0] COL    = 32'h0000_0008;
    localparam logic [31:0] MARKER = 32'hBAD0_BAD0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [31:0] m_tdata;
    logic [7:0]  m_tdest;
    logic [7:0]  m_tuser;
    logic        m_tlast;

    int n_checks = 0;
    int n_fails  = 0;
    int n_reads  = 0;
    bit finished = 1'b0;

    // Expected order of rows and tags, step 0 first
    int rows  [NST] = '{2, 0, 3};
    int dests [NST] = '{5, 1, 7};

    always #4 clk = ~clk;  // 125 MHz

    table_stream_dma #(
        .STEPS(NST), .RD_LAT(LAT),
        .BASE_ADDR(BASE), .ROW_STRIDE(STRIDE), .COL_OFFSET(COL),
        .REMOTE_TAG(8'h18),
        .ROW_SEQ({8'd3, 8'd0, 8'd2}),
        .DEST_SEQ({8'd7, 8'd1, 8'd5})
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tdest(m_tdest), .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    // Memory model: word valid only in the latency cycle, marker otherwise
    logic [LAT-1:0] pipe_v = '0;
    logic [31:0]    pipe_a [LAT];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [31:0] exp_addr(input int k);
        return BASE + 32'(rows[k]) * STRIDE + COL;
    endfunction

    always @(posedge clk) begin
        pipe_v[0] <= rd_req;
        pipe_a[0] <= rd_addr;
        for (int i = 1; i < LAT; i++) begin
            pipe_v[i] <= pipe_v[i-1];
            pipe_a[i] <= pipe_a[i-1];
        end
        if (rd_req) n_reads <= n_reads + 1;
    end

    assign rd_data = pipe_v[LAT-1] ? mem_word(pipe_a[LAT-1]) : MARKER;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        enable = 1'b1;  // R1: enable during reset has no effect
        repeat (3) @(negedge clk);
        chk(rd_req == 1'b0, "R1 rd_req in reset", 32'(rd_req), 0);
        chk(m_tvalid == 1'b0, "R1 tvalid in reset", 32'(m_tvalid), 0);
        enable = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_req == 1'b0, "R1 rd_req after reset", 32'(rd_req), 0);
    endtask

    // One run; stall = cycles of backpressure per beat; poke = raise enable mid-run
    task automatic t_run(input int stall, input bit poke);
        logic [31:0] held;
        int reads0;
        reads0 = n_reads;
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < NST; k++) begin
            if (k == 0) chk(rd_req == 1'b1, "R10 first strobe", 32'(rd_req), 1);
            else        chk(rd_req == 1'b1, "R9 next strobe", 32'(rd_req), 1);
            chk(rd_addr == exp_addr(k), "R2 address", rd_addr, exp_addr(k));
            for (int i = 1; i <= LAT; i++) begin
                if (poke) enable = 1'b1;
                @(negedge clk);
                chk(rd_req == 1'b0, "R4 strobe during wait", 32'(rd_req), 0);
                chk(m_tvalid == 1'b0, "R5 early valid", 32'(m_tvalid), 0);
            end
            enable = 1'b0;
            @(negedge clk);
            chk(m_tvalid == 1'b1, "R5 valid timing", 32'(m_tvalid), 1);
            chk(m_tdata == mem_word(exp_addr(k)), "R5 captured data", m_tdata,
                mem_word(exp_addr(k)));
            chk(m_tdest == 8'(dests[k]), "R7 tdest", 32'(m_tdest), 32'(dests[k]));
            chk(m_tuser == 8'h18, "R7 tuser", 32'(m_tuser), 32'h18);
            chk(m_tlast == (k == NST - 1), "R8 tlast", 32'(m_tlast), 32'(k == NST - 1));
            held = m_tdata;
            for (int s = 0; s < stall; s++) begin
                if (poke) enable = 1'b1;
                @(negedge clk);
                chk(m_tvalid == 1'b1 && m_tdata == held, "R6 stalled beat", m_tdata, held);
                chk(rd_req == 1'b0, "R4 strobe while valid", 32'(rd_req), 0);
            end
            enable = 1'b0;
            m_tready = 1'b1;
            @(negedge clk);
            m_tready = 1'b0;
        end
        chk(rd_req == 1'b0 && m_tvalid == 1'b0, "R8 idle after last",
            32'({rd_req, m_tvalid}), 0);
        repeat (4) begin
            @(negedge clk);
            chk(rd_req == 1'b0, "R3 no extra read", 32'(rd_req), 0);
        end
        chk(n_reads - reads0 == NST, "R3 read count", 32'(n_reads - reads0), NST);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_run(0, 1'b0);   // plain run, sink always ready on first cycle
        t_run(3, 1'b0);   // backpressure on every beat
        t_run(2, 1'b1);   // enable raised throughout the run: R10 ignored
        summary();
    end

endmodule